// File: doc/BRIEF.md
# Clock-Generator Configuration Slave (Two-Wire, Write Only)

This block receives configuration for a multi-output clock generator over a two-wire serial bus (I2C-style). A fast system clock samples the serial clock and data lines, which it treats as asynchronous. The block detects start and stop conditions and answers only to its own fixed 7-bit address in a write transfer. After that it accepts a stream of data bytes and places them in order, starting at byte 0, into a small set of configuration registers.

The registers drive five outputs:
- a 2-bit mode field;
- an enable mask for the CPU clocks;
- an enable mask for the PCI clocks, including the free-running one;
- an enable mask for the SDRAM clocks;
- an enable mask for the peripheral clocks (two interrupt-controller clocks and one reference clock).

Every enable bit comes out of reset active, so the generator runs all outputs until software switches some of them off. The block sits between the pad buffers and the output-gating logic. The data line is open-drain: the block only ever pulls it low.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, `mode` is 2'b00 and every bit of `cpu_en`, `pci_en`, `sdram_en` and `periph_en` is 1.
- R2: The block acknowledges a transfer whose first byte is address 7'b1101001 followed by R/W = 0. It does so by driving `sda_oe` high for the whole ninth clock, so the bus reads 0 while that clock is high.
- R3: In these cases the block does not acknowledge the address and ignores every later byte until the next start:
  - the address differs from 7'b1101001;
  - the R/W bit is 1.
- R4: Bytes are received MSB first. Bits [1:0] of byte 0 set `mode`: 2'b00 is normal, 2'b01 is test, 2'b11 is three-state. The code 2'b10 is stored as written.
- R5: Byte 1 bits [3:0] set `cpu_en[3:0]`. Byte 2 bits [6:0] set `pci_en[6:0]`, where bit 6 is the free-running PCI clock.
- R6: Byte 3 bits [7:0] set `sdram_en[7:0]`. Byte 4 bits [3:0] set `sdram_en[11:8]`.
- R7: Byte 5 sets `periph_en`:
  - bit 5 to `periph_en[2]` (second interrupt-controller clock);
  - bit 4 to `periph_en[1]` (first interrupt-controller clock);
  - bit 0 to `periph_en[0]` (reference clock).
- R8: Every data byte of an acknowledged transfer is acknowledged on its ninth clock. Byte 6, and every byte after it, is acknowledged but changes no output.
- R9: A stop or a repeated start ends the transfer. The next addressed transfer writes from byte 0 again.
- R10: The configuration outputs change only while `scl` is high, at the end of a data byte's eighth bit. `sda_oe` changes only while `scl` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, many times faster than `scl` |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, pull the data line low (open-drain) |
| mode | output | 2 | Operating mode field from byte 0 |
| cpu_en | output | 4 | CPU clock enables, 1 = active |
| pci_en | output | 7 | PCI clock enables; bit 6 is the free-running clock |
| sdram_en | output | 12 | SDRAM clock enables |
| periph_en | output | 3 | {interrupt-controller clock 1, interrupt-controller clock 0, reference clock} |

## Verification
The assertions check three properties on every cycle:
- the reset values of all configuration outputs;
- that the acknowledge drive starts and ends only while the serial clock is low;
- that the configuration outputs never move while the serial clock is low.

The bench scenarios cover what only a whole transfer can show:
- the address and R/W match, including the no-acknowledge cases;
- MSB-first bit order and the byte-to-field mapping;
- the discarding of byte 6 and of the bytes after it;
- the pointer restarting at byte 0 after a stop or a repeated start.

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter logic [6:0] SLAVE_ADDR = 7'b1101001,
  parameter int         NUM_BYTES  = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl,
  input  logic        sda_in,
  output logic        sda_oe,
  output logic [1:0]  mode,
  output logic [3:0]  cpu_en,
  output logic [6:0]  pci_en,
  output logic [11:0] sdram_en,
  output logic [2:0]  periph_en
);
  localparam int PTR_W = $clog2(NUM_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_DATA, S_SKIP} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  st_t        st;
  logic [7:0] shreg;
  logic [2:0] bit_cnt;
  logic [PTR_W-1:0] ptr;

  wire scl_s    = scl_sync[1];
  wire sda_s    = sda_sync[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] nxt = {shreg[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      mode      <= 2'b00;
      cpu_en    <= '1;
      pci_en    <= '1;
      sdram_en  <= '1;
      periph_en <= '1;
    end else if (start_c) begin
      st      <= S_ADDR;
      bit_cnt <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          shreg   <= nxt;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7)
            st <= (nxt == {SLAVE_ADDR, 1'b0}) ? S_ACK : S_SKIP;
        end
        S_DATA: if (scl_rise) begin
          shreg   <= nxt;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            st <= S_ACK;
            if (int'(ptr) < NUM_BYTES) ptr <= ptr + 1'b1;
            case (int'(ptr))
              0: mode            <= nxt[1:0];
              1: cpu_en          <= nxt[3:0];
              2: pci_en          <= nxt[6:0];
              3: sdram_en[7:0]   <= nxt;
              4: sdram_en[11:8]  <= nxt[3:0];
              5: periph_en       <= {nxt[5], nxt[4], nxt[0]};
              default: ;
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          if (!sda_oe) sda_oe <= 1'b1;
          else begin
            sda_oe  <= 1'b0;
            st      <= S_DATA;
            bit_cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl,
  input logic        sda_oe,
  input logic [1:0]  mode,
  input logic [3:0]  cpu_en,
  input logic [6:0]  pci_en,
  input logic [11:0] sdram_en,
  input logic [2:0]  periph_en
);
  wire [27:0] cfg = {mode, cpu_en, pci_en, sdram_en, periph_en};

  // R1
  reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'b00 && &cpu_en && &pci_en && &sdram_en && &periph_en));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> scl);

  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe), .mode(mode),
  .cpu_en(cpu_en), .pci_en(pci_en), .sdram_en(sdram_en), .periph_en(periph_en)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic [1:0] mode;
  logic [3:0] cpu_en;
  logic [6:0] pci_en;
  logic [11:0] sdram_en;
  logic [2:0] periph_en;
  wire sda_bus = !(m_low || sda_oe);
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkcfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .mode(mode), .cpu_en(cpu_en), .pci_en(pci_en), .sdram_en(sdram_en),
    .periph_en(periph_en)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req, input logic [1:0] m, input logic [3:0] c,
                         input logic [6:0] p, input logic [11:0] s, input logic [2:0] f);
    logic [27:0] a, e;
    a = {mode, cpu_en, pci_en, sdram_en, periph_en};
    e = {m, c, p, s, f};
    chk(a == e, req, 32'(a), 32'(e));
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wt(Q);
    scl = 1'b1;   wt(Q);
    m_low = 1'b1; wt(2*Q);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wt(Q);
    scl = 1'b1;   wt(Q);
    m_low = 1'b0; wt(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; wt(Q);
      scl = 1'b1;    wt(2*Q);
      scl = 1'b0;    wt(Q);
    end
    m_low = 1'b0; wt(Q);
    scl = 1'b1;   wt(Q);
    acked = (sda_bus == 1'b0);
    wt(Q);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic t_reset();
    chk_cfg("R1 reset values", 2'b00, 4'hF, 7'h7F, 12'hFFF, 3'b111);
    chk(sda_oe == 1'b0, "R1 sda idle", 32'(sda_oe), 0);
  endtask

  task automatic t_full_write();
    bit a;
    logic [7:0] data [9] = '{8'h01, 8'h0A, 8'h55, 8'hA5, 8'h0C, 8'h21, 8'h00, 8'hFF, 8'h00};
    i2c_start();
    send_byte(8'hD2, a);
    chk(a, "R2 address ack", 32'(a), 1);
    for (int k = 0; k < 9; k++) begin
      send_byte(data[k], a);
      chk(a, "R8 data byte ack", 32'(a), 1);
      if (k == 5) chk_cfg("R7 after byte 5", 2'b01, 4'hA, 7'h55, 12'hCA5, 3'b101);
    end
    i2c_stop();
    chk(mode == 2'b01, "R4 mode test", 32'(mode), 1);
    chk(cpu_en == 4'hA, "R5 cpu", 32'(cpu_en), 32'hA);
    chk(pci_en == 7'h55, "R5 pci", 32'(pci_en), 32'h55);
    chk(sdram_en == 12'hCA5, "R6 sdram", 32'(sdram_en), 32'hCA5);
    chk(periph_en == 3'b101, "R7 periph", 32'(periph_en), 32'h5);
    chk_cfg("R8 extra bytes discarded", 2'b01, 4'hA, 7'h55, 12'hCA5, 3'b101);
  endtask

  task automatic t_foreign();
    bit a;
    i2c_start();
    send_byte(8'hD0, a);
    chk(!a, "R3 wrong address nack", 32'(a), 0);
    send_byte(8'h03, a);
    chk(!a, "R3 ignored byte nack", 32'(a), 0);
    i2c_stop();
    chk_cfg("R3 wrong address no effect", 2'b01, 4'hA, 7'h55, 12'hCA5, 3'b101);
    i2c_start();
    send_byte(8'hD3, a);
    chk(!a, "R3 read bit nack", 32'(a), 0);
    send_byte(8'h03, a);
    i2c_stop();
    chk_cfg("R3 read no effect", 2'b01, 4'hA, 7'h55, 12'hCA5, 3'b101);
  endtask

  task automatic t_restart();
    bit a;
    i2c_start();
    send_byte(8'hD2, a);
    send_byte(8'h03, a);
    chk(mode == 2'b11, "R4 mode three-state", 32'(mode), 3);
    i2c_start();
    send_byte(8'hD2, a);
    chk(a, "R9 repeated start ack", 32'(a), 1);
    send_byte(8'h00, a);
    send_byte(8'h0F, a);
    i2c_stop();
    chk_cfg("R9 repeated start from byte 0", 2'b00, 4'hF, 7'h55, 12'hCA5, 3'b101);
    i2c_start();
    send_byte(8'hD2, a);
    send_byte(8'h02, a);
    i2c_stop();
    chk_cfg("R9 stop then byte 0", 2'b10, 4'hF, 7'h55, 12'hCA5, 3'b101);
  endtask

  initial begin
    wt(10);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_full_write();
    t_foreign();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule